// File: doc/BRIEF.md
# Line Parity Error Signal-Fail Monitor

Once per frame this block is handed two bytes: the line parity byte it recomputed and the parity byte it received. It turns any mismatch between them into an error count for that frame. A static mode input sets how the count is taken. In per-bit mode every differing bit counts as one error. In per-frame mode any mismatch counts as exactly one error. The per-frame count goes to a remote error indication output and is added to a saturating running total.

The same per-frame count drives three window detectors.

- **Burst signal-fail detector.** It uses a short window of `win_frames` frames and a single threshold, so it has no hysteresis.
- **Interval signal-fail detector.** Its window is eight times longer. It declares as soon as the running count of the window reaches a set threshold. It clears only at the end of a window whose count is at or below a separate, lower clear threshold.
- **Signal-degrade detector.** It applies the interval rule with its own pair of thresholds.

The signal-fail output is the OR of the burst and interval flags. All thresholds, the window length and the mode are static configuration inputs. `win_frames` must be at least 1.

Top module: `lpar_sf_monitor`

## Requirements
- R1: With `per_frame_mode`=0, the cycle after a strobed frame shows `rei_vld`=1 and `rei_cnt` equal to the number of 1 bits in `par_calc` XOR `par_rx` (0 to 8).
- R2: With `per_frame_mode`=1, `rei_cnt` is 1 for a frame whose two parity bytes differ in any bit, and 0 otherwise. The detectors consume this same value.
- R3: `err_total` adds each frame's `rei_cnt` and saturates at 65535 instead of wrapping.
- R4: The burst window spans `win_frames` strobed frames. At the window's last frame the burst flag is set if the window count is at least `burst_thr`, and cleared if it is below. At any other time the flag does not change.
- R5: The interval window spans 8×`win_frames` strobed frames. The interval flag is set in the cycle after the frame that brings the window count to at least `sf_set_thr`.
- R6: Once set, the interval flag stays set until the last frame of a window whose total is at most `sf_clr_thr` and below `sf_set_thr`. It is cleared in the cycle after that frame.
- R7: `sf_flag` is the OR of the burst flag and the interval flag.
- R8: `sd_flag` follows the interval rules of R5 and R6 on the long window, using `sd_set_thr` and `sd_clr_thr`.
- R9: While `sf_enable`=0, `sf_flag` is 0. While `sd_enable`=0, `sd_flag` is 0. Window counting continues in both cases.
- R10: In a cycle with `frm_vld`=0, nothing advances: `rei_vld` is 0 in the next cycle, and `err_total` and both flags hold.
- R11: Synchronous `rst` zeroes `rei_cnt`, `rei_vld`, `err_total`, both flags and all window state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frm_vld | input | 1 | One-cycle strobe: parity bytes valid for one frame |
| par_calc | input | 8 | Recomputed line parity byte |
| par_rx | input | 8 | Received line parity byte |
| per_frame_mode | input | 1 | 0: count per bit, 1: count per frame |
| sf_enable | input | 1 | Signal-fail detection enable |
| sd_enable | input | 1 | Signal-degrade detection enable |
| win_frames | input | WIN_W | Burst window length in frames (≥1) |
| burst_thr | input | ACC_W | Burst declare/clear threshold |
| sf_set_thr | input | ACC_W | Interval signal-fail declare threshold |
| sf_clr_thr | input | ACC_W | Interval signal-fail clear threshold |
| sd_set_thr | input | ACC_W | Signal-degrade declare threshold |
| sd_clr_thr | input | ACC_W | Signal-degrade clear threshold |
| rei_cnt | output | 4 | Error count of the last frame |
| rei_vld | output | 1 | `rei_cnt` refreshed this cycle |
| err_total | output | TOT_W | Saturating running error total |
| sf_flag | output | 1 | Signal fail |
| sd_flag | output | 1 | Signal degrade |

## Verification
Every eighth burst window ends on the same frame as an interval window. In that frame the burst flag may clear while the interval flag declares, or both may evaluate at once, and `sf_flag` must reflect both results together. A random phase with both signal-fail detectors armed and error densities that change from segment to segment drives the block into these shared boundaries. A second pair of simultaneous events is a declare and a clear falling on one interval frame, where declare must win. This happens when the final frame pushes the count over the set threshold. A bench model steps all three windows frame by frame and judges `sf_flag` and `sd_flag` in every cycle.

// File: rtl/lpar_pkg.sv
package lpar_pkg;
  localparam int PAR_W = 8;
  typedef logic [3:0] errcnt_t;

  function automatic errcnt_t popcnt8(input logic [PAR_W-1:0] v);
    errcnt_t c;
    c = '0;
    for (int i = 0; i < PAR_W; i++) c = c + {3'b000, v[i]};
    return c;
  endfunction

  function automatic errcnt_t frame_errs(input logic [PAR_W-1:0] calc,
                                         input logic [PAR_W-1:0] rx,
                                         input logic per_frame);
    errcnt_t n;
    n = popcnt8(calc ^ rx);
    if (per_frame) n = (n != 0) ? 4'd1 : 4'd0;
    return n;
  endfunction
endpackage

// File: rtl/lpar_err_tally.sv
module lpar_err_tally
  import lpar_pkg::*;
#(
  parameter int TOT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frm_vld,
  input  logic [PAR_W-1:0] par_calc,
  input  logic [PAR_W-1:0] par_rx,
  input  logic             per_frame_mode,
  output errcnt_t          frm_errs,
  output errcnt_t          rei_cnt,
  output logic             rei_vld,
  output logic [TOT_W-1:0] err_total
);
  localparam logic [TOT_W:0] TOT_MAX = {1'b0, {TOT_W{1'b1}}};

  function automatic logic [TOT_W-1:0] sat_tot(input logic [TOT_W-1:0] a, input errcnt_t b);
    logic [TOT_W:0] s;
    s = {1'b0, a} + {{(TOT_W-3){1'b0}}, b};
    return (s > TOT_MAX) ? {TOT_W{1'b1}} : s[TOT_W-1:0];
  endfunction

  assign frm_errs = frame_errs(par_calc, par_rx, per_frame_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      rei_cnt   <= '0;
      rei_vld   <= 1'b0;
      err_total <= '0;
    end else begin
      rei_vld <= frm_vld;
      if (frm_vld) begin
        rei_cnt   <= frm_errs;
        err_total <= sat_tot(err_total, frm_errs);
      end
    end
  end

  a_r1_cnt_range: assert property (@(posedge clk) disable iff (rst)
    rei_cnt <= 4'd8);
  a_r2_single_per_frame: assert property (@(posedge clk) disable iff (rst)
    (frm_vld && per_frame_mode) |=> (rei_cnt <= 4'd1));
  a_r3_total_monotonic: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (err_total >= $past(err_total)));
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !frm_vld |=> (!rei_vld && $stable(err_total)));
endmodule

// File: rtl/lpar_win_det.sv
module lpar_win_det
  import lpar_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int ACC_W = 16,
  parameter bit HYST  = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             frm_vld,
  input  errcnt_t          errs,
  input  logic [LEN_W-1:0] win_len,
  input  logic [ACC_W-1:0] set_thr,
  input  logic [ACC_W-1:0] clr_thr,
  output logic             flag
);
  localparam logic [ACC_W:0] ACC_MAX = {1'b0, {ACC_W{1'b1}}};

  logic [LEN_W-1:0] idx;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sum;
  logic [LEN_W:0]   idx_inc;
  logic             last;
  logic             win_end;

  function automatic logic [ACC_W-1:0] sat_acc(input logic [ACC_W-1:0] a, input errcnt_t b);
    logic [ACC_W:0] s;
    s = {1'b0, a} + {{(ACC_W-3){1'b0}}, b};
    return (s > ACC_MAX) ? {ACC_W{1'b1}} : s[ACC_W-1:0];
  endfunction

  assign sum     = sat_acc(acc, errs);
  assign idx_inc = {1'b0, idx} + {{LEN_W{1'b0}}, 1'b1};
  assign last    = idx_inc >= {1'b0, win_len};
  assign win_end = frm_vld && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
      acc <= '0;
    end else if (win_end) begin
      idx <= '0;
      acc <= '0;
    end else if (frm_vld) begin
      idx <= idx_inc[LEN_W-1:0];
      acc <= sum;
    end
  end

  generate
    if (HYST) begin : g_hyst
      always_ff @(posedge clk) begin
        if (rst || !en)             flag <= 1'b0;
        else if (frm_vld) begin
          if (sum >= set_thr)       flag <= 1'b1;
          else if (last && sum <= clr_thr) flag <= 1'b0;
        end
      end
      a_r6_no_midwin_clear: assert property (@(posedge clk) disable iff (rst)
        (en && flag && !win_end) |=> flag);
    end else begin : g_burst
      always_ff @(posedge clk) begin
        if (rst || !en)             flag <= 1'b0;
        else if (win_end) begin
          if (sum >= set_thr)       flag <= 1'b1;
          else if (sum < clr_thr)   flag <= 1'b0;
        end
      end
      a_r4_end_only: assert property (@(posedge clk) disable iff (rst)
        (en && !win_end) |=> $stable(flag));
    end
  endgenerate

  a_r9_disabled_low: assert property (@(posedge clk) disable iff (rst)
    !en |=> !flag);
endmodule

// File: rtl/lpar_sf_monitor.sv
module lpar_sf_monitor
  import lpar_pkg::*;
#(
  parameter int WIN_W = 8,
  parameter int ACC_W = 16,
  parameter int TOT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frm_vld,
  input  logic [7:0]       par_calc,
  input  logic [7:0]       par_rx,
  input  logic             per_frame_mode,
  input  logic             sf_enable,
  input  logic             sd_enable,
  input  logic [WIN_W-1:0] win_frames,
  input  logic [ACC_W-1:0] burst_thr,
  input  logic [ACC_W-1:0] sf_set_thr,
  input  logic [ACC_W-1:0] sf_clr_thr,
  input  logic [ACC_W-1:0] sd_set_thr,
  input  logic [ACC_W-1:0] sd_clr_thr,
  output logic [3:0]       rei_cnt,
  output logic             rei_vld,
  output logic [TOT_W-1:0] err_total,
  output logic             sf_flag,
  output logic             sd_flag
);
  localparam int IVL_W = WIN_W + 3;

  errcnt_t          frm_errs;
  logic [IVL_W-1:0] ivl_len;
  logic             sf_burst;
  logic             sf_ivl;

  assign ivl_len = {win_frames, 3'b000};

  lpar_err_tally #(.TOT_W(TOT_W)) u_tally (
    .clk(clk), .rst(rst), .frm_vld(frm_vld), .par_calc(par_calc), .par_rx(par_rx),
    .per_frame_mode(per_frame_mode), .frm_errs(frm_errs), .rei_cnt(rei_cnt),
    .rei_vld(rei_vld), .err_total(err_total)
  );

  lpar_win_det #(.LEN_W(WIN_W), .ACC_W(ACC_W), .HYST(1'b0)) u_burst (
    .clk(clk), .rst(rst), .en(sf_enable), .frm_vld(frm_vld), .errs(frm_errs),
    .win_len(win_frames), .set_thr(burst_thr), .clr_thr(burst_thr), .flag(sf_burst)
  );

  lpar_win_det #(.LEN_W(IVL_W), .ACC_W(ACC_W), .HYST(1'b1)) u_ivl (
    .clk(clk), .rst(rst), .en(sf_enable), .frm_vld(frm_vld), .errs(frm_errs),
    .win_len(ivl_len), .set_thr(sf_set_thr), .clr_thr(sf_clr_thr), .flag(sf_ivl)
  );

  lpar_win_det #(.LEN_W(IVL_W), .ACC_W(ACC_W), .HYST(1'b1)) u_sd (
    .clk(clk), .rst(rst), .en(sd_enable), .frm_vld(frm_vld), .errs(frm_errs),
    .win_len(ivl_len), .set_thr(sd_set_thr), .clr_thr(sd_clr_thr), .flag(sd_flag)
  );

  assign sf_flag = sf_burst | sf_ivl;

  a_r7_sf_covers_ivl: assert property (@(posedge clk) disable iff (rst)
    $rose(sf_ivl) |-> sf_flag);
  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (!sf_flag && !sd_flag && !rei_vld && err_total == '0));
endmodule

// File: tb/test_lpar_sf_monitor.sv
`timescale 1ns/1ps
module test_lpar_sf_monitor;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frm_vld = 1'b0;
  logic [7:0] par_calc = '0, par_rx = '0;
  logic per_frame_mode = 1'b0, sf_enable = 1'b1, sd_enable = 1'b1;
  logic [7:0] win_frames = 8'd4;
  logic [15:0] burst_thr = 16'd10, sf_set_thr = 16'd40, sf_clr_thr = 16'd8;
  logic [15:0] sd_set_thr = 16'd12, sd_clr_thr = 16'd4;
  logic [3:0] rei_cnt;
  logic rei_vld, sf_flag, sd_flag;
  logic [15:0] err_total;

  int n_chk = 0, n_err = 0;
  int m_idx[3], m_acc[3], m_flg[3];
  int m_tot, m_rei, m_vld;
  string sf_tag = "R7";

  always #4 clk = ~clk;

  lpar_sf_monitor i_lpar_sf_monitor (
    .clk(clk), .rst(rst), .frm_vld(frm_vld), .par_calc(par_calc), .par_rx(par_rx),
    .per_frame_mode(per_frame_mode), .sf_enable(sf_enable), .sd_enable(sd_enable),
    .win_frames(win_frames), .burst_thr(burst_thr), .sf_set_thr(sf_set_thr),
    .sf_clr_thr(sf_clr_thr), .sd_set_thr(sd_set_thr), .sd_clr_thr(sd_clr_thr),
    .rei_cnt(rei_cnt), .rei_vld(rei_vld), .err_total(err_total),
    .sf_flag(sf_flag), .sd_flag(sd_flag)
  );

  function automatic int exp_errs(logic [7:0] c, logic [7:0] x, logic pf);
    int n = 0;
    for (int i = 0; i < 8; i++) if (c[i] != x[i]) n++;
    if (pf) return (n > 0) ? 1 : 0;
    return n;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic mdl_det(int k, int len, int st, int cl, bit hyst, bit en, bit vld, int e);
    int sum; bit last;
    if (!en) m_flg[k] = 0;
    if (!vld) return;
    sum = m_acc[k] + e;
    if (sum > 65535) sum = 65535;
    last = (m_idx[k] + 1 >= len);
    if (en) begin
      if (hyst) begin
        if (sum >= st) m_flg[k] = 1;
        else if (last && sum <= cl) m_flg[k] = 0;
      end else if (last) begin
        if (sum >= st) m_flg[k] = 1;
        else if (sum < cl) m_flg[k] = 0;
      end
    end
    if (last) begin m_idx[k] = 0; m_acc[k] = 0; end
    else begin m_idx[k]++; m_acc[k] = sum; end
  endtask

  task automatic mdl_reset();
    for (int k = 0; k < 3; k++) begin m_idx[k] = 0; m_acc[k] = 0; m_flg[k] = 0; end
    m_tot = 0; m_rei = 0; m_vld = 0;
  endtask

  task automatic step(bit r, bit v, logic [7:0] c, logic [7:0] x);
    int e;
    rst = r; frm_vld = v; par_calc = c; par_rx = x;
    @(posedge clk);
    if (r) mdl_reset();
    else begin
      e = exp_errs(c, x, per_frame_mode);
      m_vld = v;
      if (v) begin
        m_rei = e;
        m_tot = (m_tot + e > 65535) ? 65535 : m_tot + e;
      end
      mdl_det(0, win_frames, burst_thr, burst_thr, 1'b0, sf_enable, v, e);
      mdl_det(1, win_frames * 8, sf_set_thr, sf_clr_thr, 1'b1, sf_enable, v, e);
      mdl_det(2, win_frames * 8, sd_set_thr, sd_clr_thr, 1'b1, sd_enable, v, e);
    end
    @(negedge clk);
    if (r) begin
      chk("R11 rei_vld", rei_vld, 0); chk("R11 total", err_total, 0);
      chk("R11 sf", sf_flag, 0);      chk("R11 sd", sd_flag, 0);
    end else begin
      chk(v ? "R1 rei_vld" : "R10 rei_vld idle", rei_vld, m_vld);
      if (v) chk(per_frame_mode ? "R2 rei_cnt" : "R1 rei_cnt", rei_cnt, m_rei);
      chk(v ? "R3 total" : "R10 total idle", err_total, m_tot);
      chk(sf_tag, sf_flag, m_flg[0] | m_flg[1]);
      chk(sd_enable ? "R8 sd" : "R9 sd disabled", sd_flag, m_flg[2]);
    end
  endtask

  task automatic rnd_frame(int dens, int vld_pct);
    logic [7:0] c, m;
    c = 8'($urandom);
    m = '0;
    for (int i = 0; i < 8; i++) if (($urandom % 100) < dens) m[i] = 1'b1;
    step(1'b0, ($urandom % 100) < vld_pct, c, c ^ m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    mdl_reset();
    step(1'b1, 1'b0, 8'h00, 8'h00);
    step(1'b1, 1'b1, 8'h5A, 8'hA5);
    // R1 directed corners
    step(1'b0, 1'b1, 8'h3C, 8'hC3);
    step(1'b0, 1'b1, 8'h77, 8'h77);
    step(1'b0, 1'b1, 8'h01, 8'h03);
    step(1'b0, 1'b0, 8'h00, 8'hFF);
    // R2 per-frame mode
    per_frame_mode = 1'b1;
    step(1'b0, 1'b1, 8'h00, 8'hFF);
    step(1'b0, 1'b1, 8'h10, 8'h10);
    step(1'b0, 1'b1, 8'h10, 8'h11);
    for (int i = 0; i < 300; i++) rnd_frame(40, 80);
    per_frame_mode = 1'b0;
    // R4 burst only
    step(1'b1, 1'b0, 8'h00, 8'h00);
    sf_tag = "R4 burst"; sf_set_thr = 16'hFFFF; sf_clr_thr = 16'hFFFF;
    for (int s = 0; s < 12; s++) begin
      int d = (s % 3 == 0) ? 5 : ((s % 3 == 1) ? 50 : 25);
      for (int i = 0; i < 40; i++) rnd_frame(d, 85);
    end
    // R5 and R6 interval hysteresis
    step(1'b1, 1'b0, 8'h00, 8'h00);
    sf_tag = "R5 R6 interval"; burst_thr = 16'hFFFF; win_frames = 8'd2;
    sf_set_thr = 16'd20; sf_clr_thr = 16'd5;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 8'h00, 8'hFF);
    for (int i = 0; i < 16; i++) step(1'b0, 1'b1, 8'h00, 8'h03);
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, 8'h00, 8'h00);
    for (int s = 0; s < 16; s++) begin
      int d = (s % 2 == 0) ? 3 : 20;
      for (int i = 0; i < 50; i++) rnd_frame(d, 90);
    end
    // R7 both signal-fail detectors armed
    step(1'b1, 1'b0, 8'h00, 8'h00);
    sf_tag = "R7 sf or"; burst_thr = 16'd9; sf_set_thr = 16'd60; sf_clr_thr = 16'd15;
    win_frames = 8'd3;
    for (int s = 0; s < 20; s++) begin
      int d = (s % 4 == 0) ? 35 : ((s % 4 == 2) ? 2 : 12);
      for (int i = 0; i < 48; i++) rnd_frame(d, 95);
    end
    // R9 enables off
    sf_tag = "R9 sf disabled"; sf_enable = 1'b0; sd_enable = 1'b0;
    for (int i = 0; i < 60; i++) rnd_frame(60, 90);
    sf_enable = 1'b1; sd_enable = 1'b1; sf_tag = "R7 sf or";
    for (int i = 0; i < 60; i++) rnd_frame(30, 90);
    // R11 mid-run reset
    step(1'b1, 1'b1, 8'h00, 8'hFF);
    // R3 saturation
    for (int i = 0; i < 8300; i++) step(1'b0, 1'b1, 8'h55, 8'hAA);
    chk("R3 saturated", err_total, 65535);
    step(1'b0, 1'b1, 8'h55, 8'hAA);
    chk("R3 stays saturated", err_total, 65535);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule